// File: doc/BRIEF.md
# Framed Command Packet Parser

This block sits behind a serial byte receiver and turns its byte stream into command packets. It waits for a start delimiter and then captures a header: a one-byte client selector, a one-byte burst length and a three-byte target address. The address is either a storage address or a client register index. It then forwards the data burst one byte at a time and checks a trailing CRC-8 and an end delimiter. Each packet is reported with either a `done` pulse or an `error` pulse.

Both byte interfaces use valid/ready handshakes. A byte moves when `valid` and `ready` are high on the same rising edge. On the input side, `in_ready` is high in every phase except the data burst. During the burst it falls only while the one-byte output register is full and the consumer holds `out_ready` low. While `out_ready` is low, `out_valid` and `out_data` hold their values. Header, CRC and end bytes are never stalled. A consumer that stalls the data output therefore stalls the sender. The header pins hold their last captured values, and `hdr_valid` marks the cycle in which the header becomes complete. The status pins `done` and `error` are single-cycle pulses.

Top module: `pkt_frame_parser`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `hdr_valid`, `done` and `error` are 0. `hdr_type`, `hdr_len` and `hdr_addr` are all zero.
- R2: While idle, every accepted byte other than 0x3C is dropped. The parser stays idle, `in_ready` stays 1, and no output, pulse or header change results.
- R3: After 0x3C, the next accepted byte is the type and the one after it is the length. The three bytes after those form the address, most significant byte first. `hdr_valid` pulses for one cycle in the cycle after the third address byte is accepted, with all three fields already updated.
- R4: The burst carries length+1 bytes, so 0x00 means 1 byte and 0xFF means 256 bytes. Each burst byte appears on `out_data` with `out_valid` high in the cycle after it is accepted, in arrival order.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold. During the burst, `in_ready` is 0 exactly when the output is full and stalled. It is 1 in every other phase.
- R6: The CRC is CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value 0x00, shifted most significant bit first over type, length, address and data bytes. The byte after the burst is compared with it. On a mismatch, `error` pulses in the next cycle and the parser returns to idle.
- R7: After a matching CRC, the next accepted byte is checked. If it is 0xA5, `done` pulses in the next cycle. Any other value makes `error` pulse in the next cycle and is consumed, not treated as a new start. Either way the parser returns to idle.
- R8: `done` and `error` are never high together, and neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Received byte |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Parser accepts the offered byte |
| out_data | output | 8 | Burst data byte |
| out_valid | output | 1 | `out_data` is offered |
| out_ready | input | 1 | Consumer takes `out_data` |
| hdr_type | output | 8 | Captured client selector |
| hdr_len | output | 8 | Captured length (count minus one) |
| hdr_addr | output | 24 | Captured address |
| hdr_valid | output | 1 | One-cycle pulse: header complete |
| done | output | 1 | One-cycle pulse: packet good |
| error | output | 1 | One-cycle pulse: CRC or end byte bad |

## Verification
The hardest state to reach from the ports is a full output register held by the consumer while the sender still has burst bytes to offer, and above all when this happens on the last burst byte just before the CRC byte. The bench drives `out_ready` from a pseudo-random stall pattern during long bursts, including a 256-byte one, so that this overlap occurs many times. A reference model runs beside the design and checks the stall handshake on every clock. Corrupted CRC bytes and wrong end bytes are placed after full bursts so that both error paths are reached from a fully advanced parser.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TYPE,
    ST_LEN,
    ST_ADDR,
    ST_DATA,
    ST_CRC,
    ST_END
  } pstate_t;
endpackage

// File: rtl/pkt_crc8.sv
module pkt_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  logic [7:0] nxt;

  // Byte-wide form: fold the byte in, then eight shift/reduce steps.
  always_comb begin
    nxt = crc ^ din;
    for (int i = 0; i < 8; i++) begin
      nxt = nxt[7] ? ((nxt << 1) ^ POLY) : (nxt << 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= nxt;
  end
endmodule

// File: rtl/pkt_burst_cnt.sv
module pkt_burst_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/pkt_frame_parser.sv
module pkt_frame_parser
  import pkt_pkg::*;
#(
  parameter logic [7:0] SOF_BYTE   = 8'h3C,
  parameter logic [7:0] EOF_BYTE   = 8'hA5,
  parameter logic [7:0] CRC_POLY   = 8'h07,
  parameter int         ADDR_BYTES = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BYTE_W-1:0]         in_data,
  input  logic                      in_valid,
  output logic                      in_ready,
  output logic [BYTE_W-1:0]         out_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [BYTE_W-1:0]         hdr_type,
  output logic [BYTE_W-1:0]         hdr_len,
  output logic [8*ADDR_BYTES-1:0]   hdr_addr,
  output logic                      hdr_valid,
  output logic                      done,
  output logic                      error
);
  localparam int AW  = BYTE_W * ADDR_BYTES;
  localparam int ACW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  pstate_t        state;
  logic [ACW-1:0] addr_idx;
  logic           acc;
  logic           addr_last;
  logic           burst_last;
  logic [7:0]     crc_val;
  logic           crc_clr;
  logic           crc_en;

  assign in_ready  = !(state == ST_DATA && out_valid && !out_ready);
  assign acc       = in_valid && in_ready;
  assign addr_last = (addr_idx == ACW'(ADDR_BYTES - 1));
  assign crc_clr   = acc && (state == ST_IDLE) && (in_data == SOF_BYTE);
  assign crc_en    = acc && (state == ST_TYPE || state == ST_LEN ||
                             state == ST_ADDR || state == ST_DATA);

  pkt_crc8 #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .din(in_data), .crc(crc_val)
  );

  pkt_burst_cnt #(.W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(acc && state == ST_LEN), .load_val(in_data),
    .dec(acc && state == ST_DATA), .last(burst_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_idx  <= '0;
      hdr_type  <= '0;
      hdr_len   <= '0;
      hdr_addr  <= '0;
      hdr_valid <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      hdr_valid <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (acc) begin
        case (state)
          ST_IDLE: if (in_data == SOF_BYTE) state <= ST_TYPE;
          ST_TYPE: begin
            hdr_type <= in_data;
            state    <= ST_LEN;
          end
          ST_LEN: begin
            hdr_len  <= in_data;
            addr_idx <= '0;
            state    <= ST_ADDR;
          end
          ST_ADDR: begin
            hdr_addr <= {hdr_addr[AW-BYTE_W-1:0], in_data};
            if (addr_last) begin
              hdr_valid <= 1'b1;
              state     <= ST_DATA;
            end else begin
              addr_idx <= addr_idx + 1'b1;
            end
          end
          ST_DATA: begin
            out_valid <= 1'b1;
            out_data  <= in_data;
            if (burst_last) state <= ST_CRC;
          end
          ST_CRC: begin
            if (in_data == crc_val) state <= ST_END;
            else begin
              error <= 1'b1;
              state <= ST_IDLE;
            end
          end
          ST_END: begin
            if (in_data == EOF_BYTE) done  <= 1'b1;
            else                     error <= 1'b1;
            state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: a stray byte while idle leaves the parser idle with no status pulse
  assert_idle_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && acc && in_data != SOF_BYTE) |=>
      (state == ST_IDLE && !done && !error));

  // R3: the header pulse coincides with the start of the burst phase
  assert_hdr_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (state == ST_DATA));

  // R5: a stalled output byte holds
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: never both status pulses at once
  assert_excl_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R8: done lasts one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: error lasts one cycle
  assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);
endmodule

// File: tb/sim_pkt_frame_parser.sv
module sim_pkt_frame_parser;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  in_data;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  hdr_type;
  logic [7:0]  hdr_len;
  logic [23:0] hdr_addr;
  logic        hdr_valid;
  logic        done;
  logic        error;

  int checks = 0;
  int errors = 0;
  int acc_count = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  bit stall = 1'b0;
  bit live = 1'b0;
  logic [7:0] exp_q[$];

  // reference model state
  int          m_phase;
  int          m_left;
  int          m_aidx;
  logic [7:0]  m_crc;
  logic        m_ov;
  logic [7:0]  m_od;
  logic        m_done;
  logic        m_err;
  logic        m_hv;
  logic [7:0]  m_type;
  logic [7:0]  m_len;
  logic [23:0] m_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_frame_parser u0 (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .hdr_type(hdr_type), .hdr_len(hdr_len), .hdr_addr(hdr_addr),
    .hdr_valid(hdr_valid), .done(done), .error(error)
  );

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model, advanced on each rising edge from pre-edge values
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_aidx = 0; m_crc = 8'h00;
      m_ov = 1'b0; m_od = 8'h00; m_done = 1'b0; m_err = 1'b0; m_hv = 1'b0;
      m_type = 8'h00; m_len = 8'h00; m_addr = 24'h0;
      live = 1'b0;
    end else begin
      live = 1'b1;
      m_done = 1'b0; m_err = 1'b0; m_hv = 1'b0;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected data byte", out_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R4", "burst byte order", out_data, e);
        end
      end
      if (m_ov && out_ready) m_ov = 1'b0;
      if (in_valid && in_ready) begin
        acc_count++;
        case (m_phase)
          0: if (in_data == 8'h3C) begin m_phase = 1; m_crc = 8'h00; end
          1: begin m_type = in_data; m_crc = crc_step(m_crc, in_data); m_phase = 2; end
          2: begin m_len = in_data; m_left = int'(in_data); m_crc = crc_step(m_crc, in_data);
                   m_aidx = 0; m_phase = 3; end
          3: begin
               m_addr = {m_addr[15:0], in_data};
               m_crc = crc_step(m_crc, in_data);
               m_aidx++;
               if (m_aidx == 3) begin m_hv = 1'b1; m_phase = 4; end
             end
          4: begin
               m_ov = 1'b1; m_od = in_data;
               m_crc = crc_step(m_crc, in_data);
               if (m_left == 0) m_phase = 5; else m_left--;
             end
          5: if (in_data == m_crc) m_phase = 6; else begin m_err = 1'b1; m_phase = 0; end
          default: begin
               if (in_data == 8'hA5) m_done = 1'b1; else m_err = 1'b1;
               m_phase = 0;
             end
        endcase
      end
    end
  end

  // cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && live) begin
      logic m_ready;
      m_ready = !(m_phase == 4 && m_ov && !out_ready);
      chk(in_ready == m_ready, "R5", "in_ready", in_ready, m_ready);
      chk(out_valid == m_ov, "R5", "out_valid", out_valid, m_ov);
      if (m_ov) chk(out_data == m_od, "R4", "out_data", out_data, m_od);
      chk(hdr_valid == m_hv, "R3", "hdr_valid", hdr_valid, m_hv);
      chk(hdr_type == m_type, "R3", "hdr_type", hdr_type, m_type);
      chk(hdr_len == m_len, "R3", "hdr_len", hdr_len, m_len);
      chk(hdr_addr == m_addr, "R3", "hdr_addr", hdr_addr, m_addr);
      chk(done == m_done, "R7", "done", done, m_done);
      chk(error == m_err, "R6", "error", error, m_err);
      chk(!(done && error), "R8", "done with error", {done, error}, 0);
      if (done) done_cnt++;
      if (error) err_cnt++;
    end
  end

  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  task automatic send(input logic [7:0] b);
    int n;
    n = acc_count;
    in_data = b;
    in_valid = 1'b1;
    while (acc_count == n) @(negedge clk);
    in_valid = 1'b0;
    if (($urandom % 4) == 0) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] t, input logic [7:0] l,
                            input logic [23:0] a, input bit bad_crc,
                            input bit bad_end, input string req);
    logic [7:0] c;
    logic [7:0] d;
    int d0;
    int e0;
    d0 = done_cnt;
    e0 = err_cnt;
    c = 8'h00;
    send(8'h3C);
    send(t); c = crc_step(c, t);
    send(l); c = crc_step(c, l);
    for (int i = 2; i >= 0; i--) begin
      send(a[8*i +: 8]);
      c = crc_step(c, a[8*i +: 8]);
    end
    for (int i = 0; i <= int'(l); i++) begin
      d = 8'(i * 13 + int'(t));
      exp_q.push_back(d);
      send(d);
      c = crc_step(c, d);
    end
    send(bad_crc ? ~c : c);
    if (!bad_crc) send(bad_end ? 8'h5A : 8'hA5);
    for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "burst length", exp_q.size(), 0);
    chk(hdr_type == t, req, "final type", hdr_type, t);
    chk(hdr_len == l, "R3", "final len", hdr_len, l);
    chk(hdr_addr == a, "R3", "final addr", hdr_addr, a);
    chk(done_cnt - d0 == ((bad_crc || bad_end) ? 0 : 1), req, "done count",
        done_cnt - d0, (bad_crc || bad_end) ? 0 : 1);
    chk(err_cnt - e0 == ((bad_crc || bad_end) ? 1 : 0), req, "error count",
        err_cnt - e0, (bad_crc || bad_end) ? 1 : 0);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(!done && !error && !hdr_valid, "R1", "pulses", {done, error, hdr_valid}, 0);
    chk(hdr_type == 0 && hdr_len == 0 && hdr_addr == 0, "R1", "header", hdr_addr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: stray bytes while idle
    send(8'h00); send(8'hA5); send(8'hFF); send(8'h3B);
    repeat (3) @(negedge clk);
    chk(done_cnt == 0 && err_cnt == 0, "R2", "stray pulses", done_cnt + err_cnt, 0);
    chk(in_ready == 1'b1, "R2", "idle ready", in_ready, 1);
    chk(out_valid == 1'b0, "R2", "idle output", out_valid, 0);
    chk(hdr_addr == 24'h0, "R2", "idle header", hdr_addr, 0);

    send_frame(8'h01, 8'h00, 24'h123456, 1'b0, 1'b0, "R7");  // 1-byte burst
    send_frame(8'h02, 8'h03, 24'hABCDEF, 1'b0, 1'b0, "R3");
    stall = 1'b1;
    send_frame(8'h03, 8'h10, 24'h000102, 1'b0, 1'b0, "R5");
    send_frame(8'h04, 8'hFF, 24'hFEDCBA, 1'b0, 1'b0, "R4");  // 256-byte burst
    send_frame(8'h05, 8'h07, 24'h00FF00, 1'b1, 1'b0, "R6");  // bad CRC
    send_frame(8'h06, 8'h02, 24'h55AA55, 1'b0, 1'b1, "R7");  // bad end byte
    stall = 1'b0;
    send_frame(8'h07, 8'h05, 24'h0F0F0F, 1'b0, 1'b0, "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule